// File: doc/BRIEF.md
# Subtract-with-Borrow Arithmetic Unit with Packed-Decimal Mode

This combinational unit forms the difference of an accumulator byte and an operand byte for an 8-bit accumulator processor. The incoming carry acts as an inverted borrow. A carry-in of 1 means nothing is borrowed, and a carry-in of 0 takes one extra unit away. The unit returns the difference together with carry, zero, negative and overflow status. The carry-out follows the same inverted sense, so it can be fed straight back as the next carry-in.

A decimal-mode input switches the unit from two's-complement subtraction to packed-BCD subtraction. In decimal mode the zero, negative and overflow outputs carry no defined meaning, and the unit lowers a flags-valid output to show this. Software subtracts wider numbers one byte at a time. It starts at the least significant byte with the carry set and passes each carry-out on unchanged to the next byte.

Top module: `subBorrowAlu`

## Requirements
- R1: With decMode=0, result equals (accIn − opIn − (1 − carryIn)) modulo 256.
- R2: With decMode=0, carryOut is 1 when accIn ≥ opIn + (1 − carryIn) taken as unsigned values, and 0 otherwise. A carry-out of 0 means a borrow occurred.
- R3: With decMode=0, negFlag equals bit 7 of result.
- R4: With decMode=0, zeroFlag is 1 exactly when result is 0x00.
- R5: With decMode=0, ovfFlag is 1 exactly when the signed difference of the two's-complement operands (range −128 to +127), less the borrow, falls outside −128..+127.
- R6: flagsValid is the inverse of decMode.
- R7: With decMode=1 and both operands valid packed BCD (high nibble = tens digit, low nibble = ones digit, each digit 0 to 9), result is the BCD encoding of (accIn − opIn − (1 − carryIn)) modulo 100. For example, 0x00 − 0x01 with carryIn=1 gives 0x99, and 0x46 − 0x12 with carryIn=1 gives 0x34.
- R8: With decMode=1 and valid BCD operands, carryOut is 1 when the decimal difference is 0 or more, and 0 when it is negative.
- R9: With decMode=1, each nibble is subtracted in 4 bits with the borrow from the nibble below it. When a nibble borrows, 6 is taken from its 4-bit result modulo 16. This fixes the output for non-decimal digits, for example 0x00 − 0x0A with carryIn=1 gives 0x90 with carryOut 0, and 0x0A − 0x00 with carryIn=1 gives 0x0A with carryOut 1.
- R10: A multi-byte difference is exact when the low byte is subtracted with carryIn=1 and each carryOut is fed unchanged into the next byte's carryIn. This holds in both binary and decimal mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| accIn | input | 8 | Accumulator byte (minuend) |
| opIn | input | 8 | Operand byte (subtrahend) |
| carryIn | input | 1 | Incoming carry; 0 borrows one extra unit |
| decMode | input | 1 | 1 selects packed-BCD subtraction |
| result | output | 8 | Difference byte |
| carryOut | output | 1 | Outgoing carry; 0 means a borrow occurred |
| zeroFlag | output | 1 | Result-is-zero status (binary mode) |
| negFlag | output | 1 | Result sign bit (binary mode) |
| ovfFlag | output | 1 | Signed overflow status (binary mode) |
| flagsValid | output | 1 | High when zero, negative and overflow are meaningful |

## Verification
Binary mode is tried with every operand pair under both carry-in values. This separates errors in the inverted-borrow handling, the signed-overflow rule and the zero and sign outputs, all of which an integer model predicts exactly. Decimal mode is swept over every pair of valid BCD bytes with both carry-in values. This separates the per-digit correction from plain binary subtraction and shows where the hundreds borrow appears. Hand-picked non-decimal digits expose the modulo-16 correction. Chained two-byte binary differences and four-digit decimal differences show that the carry passes cleanly from one byte to the next.

// File: rtl/subAluPkg.sv
package subAluPkg;
  localparam int DATA_W = 8;
  localparam int DIGIT_W = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic useBcd;   // select decimal difference and carry
    logic flagsEn;  // zero/negative/overflow are meaningful
  } aluCtrl_t;
endpackage

// File: rtl/subControl.sv
module subControl
  import subAluPkg::*;
(
  input  logic     decMode,
  output aluCtrl_t ctrl
);
  always_comb begin
    ctrl.useBcd  = decMode;
    ctrl.flagsEn = ~decMode;
  end
endmodule

// File: rtl/bcdDigitSub.sv
module bcdDigitSub #(
  parameter int DIGIT_W = 4
) (
  input  logic [DIGIT_W-1:0] aDig,
  input  logic [DIGIT_W-1:0] mDig,
  input  logic               borrowIn,
  output logic [DIGIT_W-1:0] outDig,
  output logic               borrowOut
);
  localparam logic [DIGIT_W-1:0] ADJUST = DIGIT_W'(6);

  logic [DIGIT_W:0] rawDiff;

  always_comb begin
    rawDiff   = {1'b0, aDig} - {1'b0, mDig} - {{DIGIT_W{1'b0}}, borrowIn};
    borrowOut = rawDiff[DIGIT_W];
    // a borrowed digit wrapped by 16; pull it back into the decimal range
    outDig    = borrowOut ? (rawDiff[DIGIT_W-1:0] - ADJUST) : rawDiff[DIGIT_W-1:0];
  end
endmodule

// File: rtl/subDatapath.sv
module subDatapath
  import subAluPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIGIT_W = 4
) (
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] opIn,
  input  logic              carryIn,
  input  aluCtrl_t          ctrl,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              zeroFlag,
  output logic              negFlag,
  output logic              ovfFlag,
  output logic              flagsValid
);
  localparam int DIGITS = DATA_W / DIGIT_W;
  localparam int MSB    = DATA_W - 1;

  // binary path: add the ones' complement of the operand plus carry
  logic [DATA_W:0]   binSum;
  logic [DATA_W-1:0] binRes;
  logic              binCarry;

  always_comb begin
    binSum   = {1'b0, accIn} + {1'b0, ~opIn} + {{DATA_W{1'b0}}, carryIn};
    binRes   = binSum[DATA_W-1:0];
    binCarry = binSum[DATA_W];
  end

  // decimal path: ripple of digit subtractors
  logic [DIGITS:0]   digBorrow;
  logic [DATA_W-1:0] bcdRes;

  assign digBorrow[0] = ~carryIn;

  for (genvar g = 0; g < DIGITS; g++) begin : gDigit
    bcdDigitSub #(.DIGIT_W(DIGIT_W)) uDigit (
      .aDig     (accIn[g*DIGIT_W +: DIGIT_W]),
      .mDig     (opIn[g*DIGIT_W +: DIGIT_W]),
      .borrowIn (digBorrow[g]),
      .outDig   (bcdRes[g*DIGIT_W +: DIGIT_W]),
      .borrowOut(digBorrow[g+1])
    );
  end

  always_comb begin
    result     = ctrl.useBcd ? bcdRes : binRes;
    carryOut   = ctrl.useBcd ? ~digBorrow[DIGITS] : binCarry;
    negFlag    = binRes[MSB];
    zeroFlag   = (binRes == '0);
    ovfFlag    = (accIn[MSB] ^ opIn[MSB]) & (accIn[MSB] ^ binRes[MSB]);
    flagsValid = ctrl.flagsEn;
  end
endmodule

// File: rtl/subBorrowAlu.sv
module subBorrowAlu
  import subAluPkg::*;
(
  input  logic [7:0] accIn,
  input  logic [7:0] opIn,
  input  logic       carryIn,
  input  logic       decMode,
  output logic [7:0] result,
  output logic       carryOut,
  output logic       zeroFlag,
  output logic       negFlag,
  output logic       ovfFlag,
  output logic       flagsValid
);
  aluCtrl_t ctrl;

  subControl uCtrl (
    .decMode(decMode),
    .ctrl   (ctrl)
  );

  subDatapath #(.DATA_W(DATA_W), .DIGIT_W(DIGIT_W)) uPath (
    .accIn     (accIn),
    .opIn      (opIn),
    .carryIn   (carryIn),
    .ctrl      (ctrl),
    .result    (result),
    .carryOut  (carryOut),
    .zeroFlag  (zeroFlag),
    .negFlag   (negFlag),
    .ovfFlag   (ovfFlag),
    .flagsValid(flagsValid)
  );
endmodule

// File: rtl/subAluChecker.sv
module subAluChecker #(
  parameter int DATA_W  = 8,
  parameter int DIGIT_W = 4
) (
  input logic [DATA_W-1:0] accIn,
  input logic [DATA_W-1:0] opIn,
  input logic              carryIn,
  input logic              decMode,
  input logic [DATA_W-1:0] result,
  input logic              carryOut,
  input logic              zeroFlag,
  input logic              negFlag,
  input logic              ovfFlag,
  input logic              flagsValid
);
  localparam int DIGITS = DATA_W / DIGIT_W;
  localparam int MAXS   = (2 ** (DATA_W - 1)) - 1;
  localparam int MINS   = -(2 ** (DATA_W - 1));

  function automatic bit isBcd(input logic [DATA_W-1:0] v);
    bit ok = 1'b1;
    for (int i = 0; i < DIGITS; i++)
      if (int'(v[i*DIGIT_W +: DIGIT_W]) > 9) ok = 1'b0;
    return ok;
  endfunction

  function automatic int bcdVal(input logic [DATA_W-1:0] v);
    int acc = 0;
    for (int i = DIGITS - 1; i >= 0; i--)
      acc = acc * 10 + int'(v[i*DIGIT_W +: DIGIT_W]);
    return acc;
  endfunction

  int borrowAmt, diffU, diffS, diffD;

  always_comb begin
    borrowAmt = carryIn ? 0 : 1;
    diffU     = int'(accIn) - int'(opIn) - borrowAmt;
    diffS     = int'($signed(accIn)) - int'($signed(opIn)) - borrowAmt;
    diffD     = bcdVal(accIn) - bcdVal(opIn) - borrowAmt;
    if (!$isunknown({accIn, opIn, carryIn, decMode})) begin
      assert_flags_valid_R6: assert (flagsValid == !decMode)
        else $error("flagsValid does not mirror decimal mode");
      if (!decMode) begin
        assert_bin_result_R1: assert (result == DATA_W'(diffU))
          else $error("binary difference wrong");
        assert_bin_carry_R2: assert (carryOut == (diffU >= 0))
          else $error("binary carry wrong");
        assert_neg_sign_R3: assert (negFlag == result[DATA_W-1])
          else $error("negative flag wrong");
        assert_zero_R4: assert (zeroFlag == (result == '0))
          else $error("zero flag wrong");
        assert_no_overflow_R5: assert (ovfFlag == ((diffS > MAXS) || (diffS < MINS)))
          else $error("overflow flag wrong");
      end else if (isBcd(accIn) && isBcd(opIn)) begin
        assert_bcd_carry_R8: assert (carryOut == (diffD >= 0))
          else $error("decimal carry wrong");
        assert_bcd_digits_R7: assert (isBcd(result))
          else $error("decimal result holds a non-decimal digit");
      end
    end
  end
endmodule

bind subBorrowAlu subAluChecker #(.DATA_W(8), .DIGIT_W(4)) uChk (
  .accIn     (accIn),
  .opIn      (opIn),
  .carryIn   (carryIn),
  .decMode   (decMode),
  .result    (result),
  .carryOut  (carryOut),
  .zeroFlag  (zeroFlag),
  .negFlag   (negFlag),
  .ovfFlag   (ovfFlag),
  .flagsValid(flagsValid)
);

// File: tb/sim_subBorrowAlu.sv
module sim_subBorrowAlu;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] accIn = 8'h00;
  logic [7:0] opIn = 8'h00;
  logic       carryIn = 1'b1;
  logic       decMode = 1'b0;
  logic [7:0] result;
  logic       carryOut, zeroFlag, negFlag, ovfFlag, flagsValid;

  int  testCount = 0;
  int  failCount = 0;
  bit  reported  = 1'b0;

  always #5 clk = ~clk;

  subBorrowAlu u0 (
    .accIn(accIn), .opIn(opIn), .carryIn(carryIn), .decMode(decMode),
    .result(result), .carryOut(carryOut), .zeroFlag(zeroFlag),
    .negFlag(negFlag), .ovfFlag(ovfFlag), .flagsValid(flagsValid)
  );

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (a=%02h m=%02h c=%0b d=%0b)",
               req, act, exp, accIn, opIn, carryIn, decMode);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] m,
                       input logic c, input logic d);
    accIn = a; opIn = m; carryIn = c; decMode = d;
    #1;
  endtask

  function automatic int toBcd(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  task automatic testReset();
    @(negedge clk);
    apply(8'h00, 8'h00, 1'b1, 1'b0);
    chk("R1 idle result", int'(result), 0);
    chk("R2 idle carry", int'(carryOut), 1);
    chk("R4 idle zero", int'(zeroFlag), 1);
    chk("R6 idle valid", int'(flagsValid), 1);
  endtask

  task automatic testBinarySweep();
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 256; a++)
        for (int m = 0; m < 256; m++) begin
          int du, ds, sa, sm, er;
          apply(8'(a), 8'(m), c[0], 1'b0);
          du = a - m - (1 - c);
          sa = (a > 127) ? a - 256 : a;
          sm = (m > 127) ? m - 256 : m;
          ds = sa - sm - (1 - c);
          er = du & 255;
          chk("R1 binary result", int'(result), er);
          chk("R2 binary carry", int'(carryOut), (du >= 0) ? 1 : 0);
          chk("R3 negative", int'(negFlag), (er >= 128) ? 1 : 0);
          chk("R4 zero", int'(zeroFlag), (er == 0) ? 1 : 0);
          chk("R5 overflow", int'(ovfFlag), (ds > 127 || ds < -128) ? 1 : 0);
        end
  endtask

  task automatic testDecimalSweep();
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 100; a++)
        for (int m = 0; m < 100; m++) begin
          int dd;
          apply(8'(toBcd(a)), 8'(toBcd(m)), c[0], 1'b1);
          dd = a - m - (1 - c);
          chk("R8 decimal carry", int'(carryOut), (dd >= 0) ? 1 : 0);
          if (dd < 0) dd += 100;
          chk("R7 decimal result", int'(result), toBcd(dd));
          chk("R6 decimal valid low", int'(flagsValid), 0);
        end
  endtask

  task automatic testDecimalCorners();
    apply(8'h00, 8'h01, 1'b1, 1'b1);
    chk("R7 0x00-0x01", int'(result), 'h99);
    chk("R8 0x00-0x01 carry", int'(carryOut), 0);
    apply(8'h46, 8'h12, 1'b1, 1'b1);
    chk("R7 0x46-0x12", int'(result), 'h34);
    chk("R8 0x46-0x12 carry", int'(carryOut), 1);
    apply(8'h50, 8'h50, 1'b0, 1'b0);
    chk("R2 equal with borrow", int'(carryOut), 0);
    chk("R1 equal with borrow", int'(result), 'hFF);
  endtask

  task automatic testNonDecimalDigits();
    apply(8'h00, 8'h0A, 1'b1, 1'b1);
    chk("R9 0x00-0x0A", int'(result), 'h90);
    chk("R9 0x00-0x0A carry", int'(carryOut), 0);
    apply(8'h0A, 8'h00, 1'b1, 1'b1);
    chk("R9 0x0A-0x00", int'(result), 'h0A);
    chk("R9 0x0A-0x00 carry", int'(carryOut), 1);
  endtask

  task automatic chainBinary(input int x, input int y);
    logic [7:0] lo, hi;
    logic c;
    apply(8'(x), 8'(y), 1'b1, 1'b0);
    lo = result; c = carryOut;
    apply(8'(x >> 8), 8'(y >> 8), c, 1'b0);
    hi = result;
    chk("R10 binary chain", int'({hi, lo}), (x - y) & 'hFFFF);
    chk("R10 binary chain carry", int'(carryOut), (x >= y) ? 1 : 0);
  endtask

  task automatic chainDecimal(input int x, input int y);
    logic [7:0] lo, hi;
    logic c;
    int d;
    apply(8'(toBcd(x % 100)), 8'(toBcd(y % 100)), 1'b1, 1'b1);
    lo = result; c = carryOut;
    apply(8'(toBcd(x / 100)), 8'(toBcd(y / 100)), c, 1'b1);
    hi = result;
    d = x - y;
    chk("R10 decimal chain carry", int'(carryOut), (d >= 0) ? 1 : 0);
    if (d < 0) d += 10000;
    chk("R10 decimal chain", int'({hi, lo}), (toBcd(d / 100) << 8) | toBcd(d % 100));
  endtask

  task automatic testChaining();
    chainBinary('h1200, 'h0001);
    chainBinary('h8000, 'h7FFF);
    chainBinary('h0000, 'h0001);
    chainBinary('hABCD, 'hABCD);
    chainDecimal(1000, 1);
    chainDecimal(4321, 1234);
    chainDecimal(0, 9999);
  endtask

  initial begin
    #2_000_000;
    testCount++;
    failCount++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    testReset();
    testBinarySweep();
    testDecimalSweep();
    testDecimalCorners();
    testNonDecimalDigits();
    testChaining();
    report();
  end
endmodule